// File: doc/BRIEF.md
# Dual-Select Serial Slave Front End

This block is the serial slave side of a host link in which two active-low selects share one serial clock, one input line and one output line. One select steers bytes to a configuration path and the other to a data path. All four serial inputs are brought into the system clock domain by two-flop synchronizers. The clock edges are detected there, and 8-bit bytes are shifted in and out most significant bit first in clock-idle-low mode (mode 0).

When a byte completes, the block raises a one-cycle strobe with the received value and a tag naming the owning path. At that same moment it loads the next transmit byte from the owning path. The output line comes with an enable, for use by a tri-state pad. When the enable drops, the line keeps its last driven level. A separate flag shows when both selects are low together, which is the case where the configuration select takes priority.

The system clock must run at least four times faster than the serial clock. The configuration path is meant for serial rates up to 6 MHz and the data path for rates up to 1 MHz.

Top module: `dual_sel_spi_slave`

## Requirements
- R1: When both selects are low, the configuration path owns the transfer: strobed bytes carry path tag 0 (`rx_path_dat` = 0) and the data path's transmit byte is not used.
- R2: When only the data select is low, strobed bytes carry path tag 1 (`rx_path_dat` = 1) and transmit data comes from `dat_tx_byte`.
- R3: When both selects are high, clock edges produce no strobe and `miso_oe` stays 0.
- R4: After 8 rising serial clock edges under one owning select, `rx_valid` pulses for exactly one cycle, with `rx_byte` holding the input bits. The first bit sampled is bit 7.
- R5: The transmit byte is loaded from the owning path when the select is asserted. Its bit 7 is on `miso` before the first rising edge, and each falling edge inside a byte moves on to the next lower bit.
- R6: At each byte completion the owning path's transmit input is loaded, so back-to-back bytes under one select send each new value in full.
- R7: A select rising before the 8th bit aborts the byte: no strobe is issued, and the next selection starts a fresh, correct byte.
- R8: `miso_oe` is 1 while a path owns the line and 0 otherwise. While it is 0, `miso` holds the last driven bit.
- R9: `both_sel` is 1 exactly when both synchronized selects are low.
- R10: After reset, `miso_oe`, `rx_valid`, `miso` and `both_sel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from host, idles low |
| mosi | input | 1 | Serial data from host |
| cs_cfg_n | input | 1 | Configuration select, active low, has priority |
| cs_dat_n | input | 1 | Data select, active low |
| cfg_tx_byte | input | DATA_W | Next transmit byte offered by the configuration path |
| dat_tx_byte | input | DATA_W | Next transmit byte offered by the data path |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the serial data pad |
| rx_valid | output | 1 | One-cycle strobe for a completed byte |
| rx_byte | output | DATA_W | Received byte |
| rx_path_dat | output | 1 | Path tag of the strobed byte: 0 config, 1 data |
| both_sel | output | 1 | Both selects low together |

## Verification
Each serial input passes two synchronizer flops. A change in a select is therefore seen on `both_sel` two system cycles later and on `miso_oe` three cycles later. The strobe follows the 8th rising edge by three cycles, and a new `miso` bit follows a falling edge by three cycles. The bench changes inputs on the falling system edge and holds every serial half period for at least five system cycles. It samples `miso` just before it raises the serial clock, and it checks enables, flags, strobe counts and the held line level five cycles after the stimulus. That way every result has settled before it is read.

// File: rtl/spi_dual_pkg.sv
// Shared types for the dual-select serial slave.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package spi_dual_pkg;

    // Owner of the serial line for the current byte.
    typedef enum logic [1:0] {
        PATH_NONE = 2'd0,
        PATH_CFG  = 2'd1,
        PATH_DAT  = 2'd2
    } path_e;

endpackage

// File: rtl/spi_sync2.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes: each bit is independent and slow relative to clk;
// RST_VAL gives the idle level of each bit.
module spi_sync2 #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end

endmodule

// File: rtl/spi_path_arb.sv
// Fixed-priority owner select for the two active-low selects.
// Assumes: inputs are already synchronized to clk.
module spi_path_arb
    import spi_dual_pkg::*;
(
    input  logic  cfg_sel_n,
    input  logic  dat_sel_n,
    output path_e sel,
    output logic  both_low
);

    // Configuration select wins; data only when config is idle.
    always_comb begin
        if (!cfg_sel_n)      sel = PATH_CFG;
        else if (!dat_sel_n) sel = PATH_DAT;
        else                 sel = PATH_NONE;
        both_low = !cfg_sel_n && !dat_sel_n;
    end

endmodule

// File: rtl/spi_byte_engine.sv
// Mode-0 byte shifter: samples on rising serial edges, shifts the
// transmit register on falling edges, and frames bytes of DATA_W bits.
// Assumes: synchronized sck/mosi, clk at least 4x the serial clock,
// and a host that leaves 3+ clk cycles between select and first edge.
module spi_byte_engine
    import spi_dual_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  path_e             sel,
    input  logic [DATA_W-1:0] cfg_tx,
    input  logic [DATA_W-1:0] dat_tx,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_path_dat,
    output logic              miso,
    output logic              miso_oe
);

    localparam int                CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(DATA_W - 1);

    logic              sck_d;
    logic              rise, fall, owner_ok;
    path_e             own_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] rx_sh, tx_sh, tx_pick;
    logic              hold_q;

    // Edge history of the synchronized serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Edge detect, owner check and transmit source choice.
    always_comb begin
        rise     = sck_s && !sck_d;
        fall     = !sck_s && sck_d;
        owner_ok = (sel != PATH_NONE) && (sel == own_q);
        tx_pick  = (sel == PATH_DAT) ? dat_tx : cfg_tx;
    end

    // Byte framing: shift in, count, strobe, reload or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q       <= PATH_NONE;
            cnt_q       <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            rx_valid    <= 1'b0;
            rx_data     <= '0;
            rx_path_dat <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            own_q    <= sel;
            if (!owner_ok) begin
                cnt_q <= '0;
                if (sel != PATH_NONE) tx_sh <= tx_pick;
            end else if (rise) begin
                rx_sh <= {rx_sh[DATA_W-2:0], mosi_s};
                if (cnt_q == LAST) begin
                    cnt_q       <= '0;
                    rx_valid    <= 1'b1;
                    rx_data     <= {rx_sh[DATA_W-2:0], mosi_s};
                    rx_path_dat <= (own_q == PATH_DAT);
                    tx_sh       <= tx_pick;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (fall && (cnt_q != '0)) begin
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    // Bus-hold register tracks the driven bit while a path owns the line.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_q <= 1'b0;
        else if (own_q != PATH_NONE) hold_q <= tx_sh[DATA_W-1];
    end

    // Drive the current bit when owned, otherwise the held level.
    always_comb begin
        miso_oe = (own_q != PATH_NONE);
        miso    = miso_oe ? tx_sh[DATA_W-1] : hold_q;
    end

    // R4: a byte strobe never lasts longer than one cycle.
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8: with the enable low, the line level does not move.
    p_bus_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!miso_oe && $past(!miso_oe)) |-> $stable(miso));

endmodule

// File: rtl/dual_sel_spi_slave.sv
// Top of the dual-select serial slave: synchronizers, fixed-priority
// owner select and the byte engine.
// Assumes: selects are active low, clock idles low, clk >= 4x sck.
module dual_sel_spi_slave
    import spi_dual_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              cs_cfg_n,
    input  logic              cs_dat_n,
    input  logic [DATA_W-1:0] cfg_tx_byte,
    input  logic [DATA_W-1:0] dat_tx_byte,
    output logic              miso,
    output logic              miso_oe,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_path_dat,
    output logic              both_sel
);

    logic  sck_s, mosi_s, cfg_s, dat_s;
    path_e sel;

    // Bring the four serial pins into the clk domain (selects idle high).
    spi_sync2 #(
        .W       (4),
        .RST_VAL (4'b1100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({cs_dat_n, cs_cfg_n, mosi, sck}),
        .q_sync  ({dat_s, cfg_s, mosi_s, sck_s})
    );

    // Choose the owning path from the synchronized selects.
    spi_path_arb u_arb (
        .cfg_sel_n (cfg_s),
        .dat_sel_n (dat_s),
        .sel       (sel),
        .both_low  (both_sel)
    );

    // Shift, frame and drive bytes for the owning path.
    spi_byte_engine #(
        .DATA_W (DATA_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_s       (sck_s),
        .mosi_s      (mosi_s),
        .sel         (sel),
        .cfg_tx      (cfg_tx_byte),
        .dat_tx      (dat_tx_byte),
        .rx_valid    (rx_valid),
        .rx_data     (rx_byte),
        .rx_path_dat (rx_path_dat),
        .miso        (miso),
        .miso_oe     (miso_oe)
    );

    // R1: a byte completed while config was selected is tagged config.
    p_cfg_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(cfg_s)) |-> !rx_path_dat);

    // R3: no strobe for a byte finished while nothing was selected.
    p_no_idle_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !($past(cfg_s) && $past(dat_s)));

    // R3: with both selects idle the line is released a cycle later.
    p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_s) && $past(dat_s)) |-> !miso_oe);

    // R9: the collision flag only rises with the config select low.
    p_flag_needs_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        both_sel |-> (!cfg_s && !dat_s));

endmodule

// File: tb/dual_sel_spi_slave_tb.sv
`timescale 1ns/1ps
module dual_sel_spi_slave_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, mosi = 1'b0;
    logic       cs_cfg_n = 1'b1, cs_dat_n = 1'b1;
    logic [7:0] cfg_tx_byte = 8'h00, dat_tx_byte = 8'h00;
    logic       miso, miso_oe, rx_valid, rx_path_dat, both_sel;
    logic [7:0] rx_byte;

    int         checks = 0;
    int         errors = 0;
    int         rx_cnt = 0;
    logic [7:0] last_rx = 8'h00;
    logic       last_path = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    dual_sel_spi_slave #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi),
        .cs_cfg_n(cs_cfg_n), .cs_dat_n(cs_dat_n),
        .cfg_tx_byte(cfg_tx_byte), .dat_tx_byte(dat_tx_byte),
        .miso(miso), .miso_oe(miso_oe), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_path_dat(rx_path_dat), .both_sel(both_sel)
    );

    // Record every strobe, sampled away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt    <= rx_cnt + 1;
            last_rx   <= rx_byte;
            last_path <= rx_path_dat;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expected owner: 0 none, 1 config, 2 data (config has priority).
    function automatic int owner_of(input bit cfg_n, input bit dat_n);
        if (!cfg_n)      return 1;
        else if (!dat_n) return 2;
        return 0;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send nb bits of mo MSB first; collect miso before each rise.
    task automatic send_bits(input logic [7:0] mo, input int nb, input int half,
                             input int own, input logic [7:0] nxt,
                             output logic [7:0] got, output bit oe_any);
        got    = 8'h00;
        oe_any = 1'b0;
        for (int i = 7; i > 7 - nb; i--) begin
            mosi = mo[i];
            wait_n(half);
            got[i] = miso;
            oe_any = oe_any | miso_oe;
            sck = 1'b1;
            if (i == 7) begin
                if (own == 1) cfg_tx_byte = nxt;
                if (own == 2) dat_tx_byte = nxt;
            end
            wait_n(half);
            sck = 1'b0;
        end
        wait_n(4);
    endtask

    task automatic run_txn(input bit cfg_n, input bit dat_n, input int nbytes);
        int         own;
        int         half;
        int         snap;
        logic [7:0] txv [4];
        logic [7:0] mo, got;
        bit         oe_any;
        own  = owner_of(cfg_n, dat_n);
        half = (own == 2) ? 10 : 5;
        for (int k = 0; k < 4; k++) txv[k] = 8'($urandom);
        cfg_tx_byte = (own == 1) ? txv[0] : 8'($urandom);
        dat_tx_byte = (own == 2) ? txv[0] : 8'($urandom);
        cs_cfg_n = cfg_n;
        cs_dat_n = dat_n;
        wait_n(5);
        chk(both_sel == (!cfg_n && !dat_n), "R9 both_sel", int'(both_sel), int'(!cfg_n && !dat_n));
        chk(miso_oe == (own != 0), "R8 enable while selected", int'(miso_oe), int'(own != 0));
        for (int b = 0; b < nbytes; b++) begin
            mo   = 8'($urandom);
            snap = rx_cnt;
            send_bits(mo, 8, half, own, txv[b+1], got, oe_any);
            if (own == 0) begin
                chk(rx_cnt == snap, "R3 no strobe when idle", rx_cnt - snap, 0);
                chk(!oe_any, "R3 line released when idle", int'(oe_any), 0);
            end else begin
                chk(got == txv[b], (b == 0) ? "R5 transmit byte" : "R6 back-to-back reload",
                    int'(got), int'(txv[b]));
                chk(rx_cnt == snap + 1, "R4 one strobe per byte", rx_cnt - snap, 1);
                chk(last_rx == mo, "R4 received byte", int'(last_rx), int'(mo));
                if (own == 1)
                    chk(last_path == 1'b0, "R1 config tag", int'(last_path), 0);
                else
                    chk(last_path == 1'b1, "R2 data tag", int'(last_path), 1);
            end
        end
        cs_cfg_n = 1'b1;
        cs_dat_n = 1'b1;
        wait_n(5);
        chk(!miso_oe, "R8 enable drops", int'(miso_oe), 0);
        if (own != 0)
            chk(miso == txv[nbytes][7], "R8 bus hold after byte", int'(miso), int'(txv[nbytes][7]));
    endtask

    // Directed: abort mid-byte, then a fresh byte on reselect.
    task automatic run_abort();
        logic [7:0] a, bb, mo, got;
        bit         oe_any;
        int         snap;
        a  = 8'hA6;
        bb = 8'h3C;
        cfg_tx_byte = a;
        cs_cfg_n = 1'b0;
        wait_n(5);
        snap = rx_cnt;
        send_bits(8'hF0, 4, 5, 1, bb, got, oe_any);
        chk(got[7:4] == a[7:4], "R5 partial byte bits", int'(got[7:4]), int'(a[7:4]));
        cs_cfg_n = 1'b1;
        wait_n(6);
        chk(rx_cnt == snap, "R7 no strobe on abort", rx_cnt - snap, 0);
        chk(!miso_oe, "R8 enable drops on abort", int'(miso_oe), 0);
        chk(miso == a[3], "R8 bus hold mid-byte", int'(miso), int'(a[3]));
        cs_cfg_n = 1'b0;
        wait_n(5);
        mo = 8'h5A;
        send_bits(mo, 8, 5, 1, 8'h00, got, oe_any);
        chk(got == bb, "R7 fresh transmit after abort", int'(got), int'(bb));
        chk(rx_cnt == snap + 1 && last_rx == mo, "R7 fresh receive after abort",
            int'(last_rx), int'(mo));
        cs_cfg_n = 1'b1;
        wait_n(5);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        chk(!miso_oe, "R10 reset enable", int'(miso_oe), 0);
        chk(!rx_valid, "R10 reset strobe", int'(rx_valid), 0);
        chk(!miso, "R10 reset line", int'(miso), 0);
        chk(!both_sel, "R10 reset flag", int'(both_sel), 0);
        // Directed corners: each select pattern, multi-byte, abort.
        run_txn(1'b0, 1'b0, 2);   // R1 both low
        run_txn(1'b1, 1'b0, 3);   // R2 data only
        run_txn(1'b1, 1'b1, 1);   // R3 none
        run_txn(1'b0, 1'b1, 3);   // config only, R6
        run_abort();              // R7
        for (int t = 0; t < 30; t++) begin
            run_txn(1'($urandom), 1'($urandom), 1 + int'($urandom % 3));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule